// File: doc/BRIEF.md
# Fractional microsecond timebase

This block derives a steady one-microsecond enable from whatever oscillator clocks it. A small accumulator adds a programmable numerator every clock and, each time the running sum reaches a programmable denominator, emits a one-cycle tick and subtracts the denominator. Ratios that are not whole numbers, such as 96/5 for a 19.2 MHz oscillator, therefore come out exactly right on average.

Each tick advances a free-running 32-bit microsecond counter. The tick is also driven out so that neighbouring timers can use it as their enable.

Software reaches three words through a request/response port. Requests use valid/ready. Reads return one response over a valid/ready channel, and that response is held until it is taken. A request is accepted only while no response is waiting or while the waiting response is being taken in the same cycle, so a stalled reader throttles the request side. Writes produce no response.

Top module: `usec_timebase`

## Requirements
- R1: After reset the counter reads 0, the ratio word reads 0x0000000B, the hold word reads 0, no response is pending and the tick output is low.
- R2: The ratio word at offset 0x14 keeps bits [15:0] of the written data and reads them back unchanged, with bits [31:16] reading as zero.
- R3: The ratio word's bits [15:8] hold the numerator minus one and bits [7:0] hold the denominator minus one. Tick pulses are one cycle wide and occur numerator/denominator times per clock on average (0x000B: 100 ticks in 1200 cycles; 0x045F: 50 in 960; 0x0019: 20 in 520; each within one).
- R4: The counter at offset 0x10 rises by exactly one on the clock edge that raises the tick output, and it does not change at any other edge unless it is written.
- R5: While bit 0 of the hold word at offset 0x4C is 1, no tick is produced and the counter and accumulator keep their values. The bit reads back as written.
- R6: A write to offset 0x10 loads the counter, and this load takes priority over a tick in the same cycle. The counter wraps from 0xFFFFFFFF to 0.
- R7: A request is accepted when req_valid and req_ready are both high. An accepted read produces exactly one response in the next cycle, with rsp_rdata held stable while rsp_valid is high and rsp_ready is low. A write produces no response.
- R8: Reads of any other offset return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 32 | Read data |
| tick_1us | output | 1 | One-cycle microsecond enable |

## Verification
The properties assume the ratio word keeps the numerator no larger than the denominator, and the stimulus only ever writes such ratios. They also assume that the consumer, once it lowers rsp_ready, holds the request fields only while req_valid is high. The bench drives every request from a task that keeps req_valid and its fields steady until acceptance. Counter checks allow a few counts of slack across read windows, because the acceptance cycle shifts with back-pressure. Checks made while the hold bit is set and exact readbacks use no slack.

// File: rtl/utb_pkg.sv
package utb_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned FRAC_W   = 8;
  localparam int unsigned CFG_W    = 2 * FRAC_W;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RATIO = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_HOLD  = 8'h4C;
  localparam logic [CFG_W-1:0]  RATIO_RST = 16'h000B;
endpackage

// File: rtl/utb_frac_accum.sv
module utb_frac_accum #(
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [FRAC_W-1:0] num_m1,
  input  logic [FRAC_W-1:0] den_m1,
  output logic              fire,
  output logic              tick_q
);
  localparam int unsigned AW = FRAC_W + 1;
  localparam int unsigned SW = FRAC_W + 2;

  logic [AW-1:0] acc_q, acc_d;
  logic [SW-1:0] num, den, sum, rem;

  always_comb begin
    num  = SW'(num_m1) + SW'(1);
    den  = SW'(den_m1) + SW'(1);
    sum  = SW'(acc_q) + num;
    fire = run && (sum >= den);
    rem  = sum - den;
    if (sum >= den) acc_d = (rem >= den) ? '0 : AW'(rem);
    else            acc_d = AW'(sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= fire;
      if (run) acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/utb_us_counter.sv
module utb_us_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/utb_regs.sv
module utb_regs
  import utb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] count,
  output logic [CFG_W-1:0]  ratio,
  output logic              hold,
  output logic              count_load
);
  logic              take;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready  = !rsp_valid || rsp_ready;
  assign take       = req_valid && req_ready;
  assign count_load = take && req_write && (req_addr == OFS_COUNT);

  always_comb begin
    unique case (req_addr)
      OFS_COUNT: rd_mux = count;
      OFS_RATIO: rd_mux = DATA_W'(ratio);
      OFS_HOLD:  rd_mux = DATA_W'(hold);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio     <= RATIO_RST;
      hold      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (take && req_write) begin
        if (req_addr == OFS_RATIO) ratio <= req_wdata[CFG_W-1:0];
        if (req_addr == OFS_HOLD)  hold  <= req_wdata[0];
      end
      if (take && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_mux;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import utb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              tick_1us
);
  logic [DATA_W-1:0] cnt_w;
  logic [CFG_W-1:0]  cfg_w;
  logic              frz_w;
  logic              ld_w;
  logic              fire_w;

  utb_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .count(cnt_w), .ratio(cfg_w), .hold(frz_w), .count_load(ld_w)
  );

  utb_frac_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .run(!frz_w),
    .num_m1(cfg_w[CFG_W-1:FRAC_W]), .den_m1(cfg_w[FRAC_W-1:0]),
    .fire(fire_w), .tick_q(tick_1us)
  );

  utb_us_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(fire_w),
    .load(ld_w), .load_val(req_wdata), .count(cnt_w)
  );
endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [7:0]  req_addr,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        tick_1us,
  input logic [31:0] cnt,
  input logic [15:0] cfg,
  input logic        frz
);
  logic acc_ok, ld_cnt, wr_cfg;
  assign acc_ok = req_valid && req_ready;
  assign ld_cnt = acc_ok && req_write && (req_addr == 8'h10);
  assign wr_cfg = acc_ok && req_write && (req_addr == 8'h14);

  // R4
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1us && !$past(ld_cnt)) |-> (cnt == $past(cnt) + 32'd1));

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frz) && !$past(ld_cnt)) |-> ($stable(cnt) && !tick_1us));

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R7
  rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !req_write) |=> rsp_valid);

  // R2
  cfg_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (cfg == $past(req_wdata[15:0])));
endmodule

bind usec_timebase usec_timebase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .tick_1us(tick_1us), .cnt(cnt_w), .cfg(cfg_w), .frz(frz_w)
);

// File: tb/sim_usec_timebase.sv
module sim_usec_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        tick_1us;

  always #5 clk = ~clk;

  usec_timebase u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .tick_1us(tick_1us)
  );

  // kind: 0 exact, 1 delta from last counter read, 2 capture only
  typedef struct {
    logic [31:0] exp;
    logic [31:0] tol;
    int          kind;
    bit          is_cnt;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] last_cnt = '0;
  bit          stall = 1'b0;
  bit          done = 1'b0;

  initial forever begin
    @(posedge clk);
    #1 rsp_ready = !stall;
  end

  // monitor: pairs seen at the negedge before their accepting edge
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R7 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        item_t it;
        logic [31:0] ref_v, d;
        it = sb.pop_front();
        if (it.kind != 2) begin
          ref_v = (it.kind == 1) ? last_cnt + it.exp : it.exp;
          d = rsp_rdata - ref_v;
          n_cmp++;
          if (!(d <= it.tol || (32'd0 - d) <= it.tol)) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h tol=%0d", it.tag, rsp_rdata, ref_v, it.tol);
          end
        end
        if (it.is_cnt) last_cnt = rsp_rdata;
      end
    end
  end

  task automatic bus(input bit wr, input logic [7:0] a, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int kind, input logic [31:0] e,
                    input logic [31:0] tol, input string tag);
    item_t it;
    it.exp = e; it.tol = tol; it.kind = kind; it.is_cnt = (a == 8'h10); it.tag = tag;
    sb.push_back(it);
    bus(1'b0, a, '0);
  endtask

  task automatic ticks(input int n, input int e, input int tol, input string tag);
    int c = 0;
    repeat (n) begin
      @(negedge clk);
      if (tick_1us) c++;
    end
    n_cmp++;
    if (c > e + tol || c < e - tol) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, c, e);
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int e);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, e);
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(tick_1us == 1'b0 && rsp_valid == 1'b0, "R1 idle outputs", int'(tick_1us), 0);
    rd(8'h10, 0, 32'h0, 0, "R1 counter reset");
    rd(8'h14, 0, 32'h0000000B, 0, "R1 ratio reset");
    rd(8'h4C, 0, 32'h0, 0, "R1 hold reset");
    rd(8'h20, 0, 32'h0, 0, "R8 unmapped read");

    ticks(1200, 100, 1, "R3 ratio 0x000B");
    bus(1'b1, 8'h14, 32'h0000045F);
    rd(8'h14, 0, 32'h0000045F, 0, "R2 ratio readback");
    ticks(960, 50, 1, "R3 ratio 0x045F");
    bus(1'b1, 8'h14, 32'h00000019);
    ticks(520, 20, 1, "R3 ratio 0x0019");

    bus(1'b1, 8'h14, 32'hABCD1234);
    rd(8'h14, 0, 32'h00001234, 0, "R2 upper bits dropped");
    bus(1'b1, 8'h14, 32'h00000003);
    rd(8'h10, 2, 0, 0, "capture");
    repeat (400) @(negedge clk);
    rd(8'h10, 1, 32'd100, 3, "R4 counter delta at ratio 1/4");

    bus(1'b1, 8'h4C, 32'h1);
    rd(8'h4C, 0, 32'h1, 0, "R5 hold readback");
    rd(8'h10, 2, 0, 0, "capture");
    ticks(300, 0, 0, "R5 no tick while held");
    rd(8'h10, 1, 32'd0, 0, "R5 counter held");

    bus(1'b1, 8'h10, 32'hFFFFFFFF);
    rd(8'h10, 0, 32'hFFFFFFFF, 0, "R6 counter load");
    bus(1'b1, 8'h14, 32'h0);
    bus(1'b1, 8'h4C, 32'h0);
    repeat (20) @(negedge clk);
    bus(1'b1, 8'h4C, 32'h1);
    rd(8'h10, 1, 32'd23, 4, "R6 counter wrap");

    bus(1'b1, 8'h20, 32'hFFFFFFFF);
    rd(8'h14, 0, 32'h0, 0, "R8 ratio untouched");
    rd(8'h4C, 0, 32'h1, 0, "R8 hold untouched");
    rd(8'h20, 0, 32'h0, 0, "R8 unmapped still zero");

    stall = 1'b1;
    @(posedge clk); #2;
    rd(8'h14, 0, 32'h0, 0, "R7 data after stall");
    repeat (5) @(negedge clk);
    check(rsp_valid == 1'b1, "R7 response waits", int'(rsp_valid), 1);
    check(req_ready == 1'b0, "R7 request blocked", int'(req_ready), 0);
    stall = 1'b0;
    rd(8'h4C, 0, 32'h1, 0, "R7 read after release");

    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R7 all responses seen", sb.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1'b1;
    $finish;
  end
endmodule